// File: doc/BRIEF.md
# Pulse Charge Control Sequencer

This block runs the charge sequence for a single lithium cell by switching an external constant-current or current-limited source on and off. It reads a digitised cell voltage and a signed cell temperature, a flag that says a charger is attached, and a flag that says the measurements are valid. From these it drives two active-low gates. The recovery gate feeds a reduced current into a deeply discharged cell. The fast gate carries the main charge current.

A fast charge begins on a start command or, if automatic start is enabled, when a charger is attached. The charge first runs in a bulk phase. At the constant-voltage level it moves into a pulse phase, where each on-pulse has a fixed length and the gate stays off until the cell relaxes. If relaxation takes longer than a set number of pulse lengths, the charge is complete. While charging, the fast gate is released at regular intervals so that a missing charger can be detected. Over-temperature and a down-counting charge timer also end a charge.

All intervals are counted in periods of a slow `tick` input, so the same logic runs in real time or in compressed time. A two-bit status code reports the charge state. The completion code stays latched until a status write.

Top module: `pulse_charge_ctrl`

## Requirements
- R1: One cycle after any cycle in which `chg_present` is 1 and `vcell` is below `LB_CODE`, `trickle_gate_n` is 0, whatever the temperature, `data_valid` or sequencer state. One cycle after any other cycle it is 1.
- R2: A pending charge is created by a `start_cmd` pulse, or by a 0-to-1 change of `chg_present` while `auto_start` is 1. With `auto_start` at 0, attaching a charger does not start a charge.
- R3: A pending charge enters fast charge only in a cycle in which all of these hold: a charger is present, `data_valid` is 1, `vcell` is at least `LB_CODE`, and `tcell` is in the inclusive range `T_LO`..`T_HI`. Fast charge begins at the next edge, with the fast gate low.
- R4: In the bulk phase the fast gate is low until `vcell` reaches `CV_CODE`. It then stays low for `PULSE_TICKS` more ticks and goes high. It goes low again at the edge after a cycle in which `vcell` is below `CV_CODE`, and stays low for another `PULSE_TICKS` ticks.
- R5: If the fast gate stays high in the pulse phase for `DECAY_PERIODS` × `PULSE_TICKS` ticks without `vcell` falling below `CV_CODE`, the charge completes.
- R6: During fast charge the fast gate is forced high for the last `PROBE_OFF` ticks of every `PROBE_PERIOD` ticks, counted from the first fast-charge cycle.
- R7: A `stop_cmd` aborts a pending or running charge at the next edge. A missing charger aborts a running charge only in a cycle in which the fast gate is high. An abort does not set the completion code.
- R8: A `tcell` strictly above `T_MAX` in any fast-charge cycle completes the charge at the next edge.
- R9: An 8-bit charge timer loads `timer_init` when fast charge begins and decrements once every `TIMER_TICKS` ticks of fast charge. A `timer_wr` pulse overwrites it with `timer_wdata`. A fast-charge cycle that sees it at zero completes the charge at the next edge.
- R10: `status` is 3 (complete) from the edge that ends a charge until the edge after a `status_wr` pulse. Otherwise it is 1 (charging) during fast charge or while the recovery gate is low, 2 when a charger is present, and 0 when none is present.
- R11: After completion the fast gate is high, and crossings of `CV_CODE` by `vcell` leave it high until a new initiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; every interval counts these |
| vcell | input | VW | Unsigned cell voltage code |
| tcell | input | TW | Signed cell temperature code |
| chg_present | input | 1 | Charger attached |
| data_valid | input | 1 | Measurements valid |
| start_cmd | input | 1 | Start-charge strobe |
| stop_cmd | input | 1 | Stop-charge strobe |
| auto_start | input | 1 | Allow start on charger attach |
| status_wr | input | 1 | Status write strobe, clears completion |
| timer_init | input | TMW | Charge timer value loaded at fast-charge start |
| timer_wr | input | 1 | Charge timer overwrite strobe |
| timer_wdata | input | TMW | Charge timer overwrite value |
| fast_gate_n | output | 1 | Active-low fast charge gate |
| trickle_gate_n | output | 1 | Active-low recovery gate |
| status | output | 2 | Charge status code |

## Verification
The hardest case to reach is charger removal that must wait for a probe window. While the fast gate is low, a missing charger has no effect. The abort happens only at the first released cycle, which can be many ticks later. The bench shrinks the probe period through parameters, drops `chg_present` just after a window has closed, and checks that `status` still reads charging one cycle before the next window and reads no-charger one cycle after it opens. The decay limit and the timer overwrite are reached in the same way, with compressed tick ratios and exact cycle counts taken from the first fast-charge cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BULK,
        ST_HOLD,
        ST_REST
    } seq_state_t;

    localparam logic [1:0] CS_NONE     = 2'd0;
    localparam logic [1:0] CS_CHARGING = 2'd1;
    localparam logic [1:0] CS_PRESENT  = 2'd2;
    localparam logic [1:0] CS_DONE     = 2'd3;

    // Qualified conditions fed to the sequencer each cycle
    typedef struct packed {
        logic v_lb;      // cell at or above low-battery level
        logic v_cv;      // cell at or above constant-voltage level
        logic t_ok;      // temperature inside start window
        logic t_hot;     // temperature above charge maximum
        logic chg;       // charger attached
        logic chg_rise;  // charger just attached
        logic dv;        // measurements valid
        logic start;
        logic stop;
        logic auto_on;
    } seq_in_t;

    // Per-cycle control produced by the sequencer
    typedef struct packed {
        logic launch;     // entering fast charge this cycle
        logic finish;     // completion this cycle
        logic pulse_clr;  // restart the pulse interval
        logic gate_on;    // fast gate driven on
    } seq_ctl_t;

    function automatic logic is_fast(input seq_state_t s);
        return (s == ST_BULK) || (s == ST_HOLD) || (s == ST_REST);
    endfunction

    function automatic logic [1:0] pick_status(input logic done,
                                               input logic active,
                                               input logic present);
        if (done)         return CS_DONE;
        else if (active)  return CS_CHARGING;
        else if (present) return CS_PRESENT;
        else              return CS_NONE;
    endfunction

endpackage

// File: rtl/pcc_interval.sv
module pcc_interval #(
    parameter int unsigned LIMIT = 8,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pcc_charge_timer.sv
module pcc_charge_timer #(
    parameter int unsigned TMW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [TMW-1:0] load_val,
    input  logic           wr,
    input  logic [TMW-1:0] wdata,
    input  logic           dec,
    output logic           zero
);
    logic [TMW-1:0] val;

    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (load)
            val <= load_val;
        else if (wr)
            val <= wdata;
        else if (dec && (val != '0))
            val <= val - 1'b1;
    end

    assign zero = (val == '0);
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
    import pcc_pkg::*;
#(
    parameter int unsigned DECAY_PERIODS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_in_t    cin,
    input  logic       probe_win,
    input  logic       pulse_wrap,
    input  logic       timer_zero,
    output seq_state_t state,
    output seq_ctl_t   ctl
);
    localparam int unsigned  DCW       = $clog2(DECAY_PERIODS + 1);
    localparam logic [DCW-1:0] DEC_LAST = DCW'(DECAY_PERIODS - 1);

    seq_state_t     nxt;
    logic [DCW-1:0] decay_cnt, decay_nxt;
    logic           released;

    always_comb begin
        ctl.gate_on = ((state == ST_BULK) || (state == ST_HOLD)) && !probe_win;
        released    = is_fast(state) && !ctl.gate_on;
    end

    always_comb begin
        nxt           = state;
        decay_nxt     = decay_cnt;
        ctl.launch    = 1'b0;
        ctl.finish    = 1'b0;
        ctl.pulse_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!cin.stop && (cin.start || (cin.auto_on && cin.chg_rise)))
                    nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (cin.stop)
                    nxt = ST_IDLE;
                else if (cin.chg && cin.dv && cin.t_ok && cin.v_lb) begin
                    nxt        = ST_BULK;
                    ctl.launch = 1'b1;
                end
            end
            default: begin
                if (cin.stop || (released && !cin.chg)) begin
                    nxt = ST_IDLE;
                end else if (cin.t_hot || timer_zero) begin
                    nxt        = ST_IDLE;
                    ctl.finish = 1'b1;
                end else begin
                    unique case (state)
                        ST_BULK: begin
                            if (cin.v_cv) begin
                                nxt           = ST_HOLD;
                                ctl.pulse_clr = 1'b1;
                            end
                        end
                        ST_HOLD: begin
                            if (pulse_wrap) begin
                                nxt           = ST_REST;
                                ctl.pulse_clr = 1'b1;
                                decay_nxt     = '0;
                            end
                        end
                        default: begin
                            if (!cin.v_cv) begin
                                nxt           = ST_HOLD;
                                ctl.pulse_clr = 1'b1;
                            end else if (pulse_wrap) begin
                                if (decay_cnt == DEC_LAST) begin
                                    nxt        = ST_IDLE;
                                    ctl.finish = 1'b1;
                                end else begin
                                    decay_nxt = decay_cnt + 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            decay_cnt <= '0;
        end else begin
            state     <= nxt;
            decay_cnt <= decay_nxt;
        end
    end
endmodule

// File: rtl/pulse_charge_ctrl.sv
module pulse_charge_ctrl
    import pcc_pkg::*;
#(
    parameter int unsigned VW            = 10,
    parameter int unsigned TW            = 11,
    parameter int unsigned TMW           = 8,
    parameter int unsigned LB_CODE       = 615,
    parameter int unsigned CV_CODE       = 861,
    parameter int          T_LO          = 0,
    parameter int          T_HI          = 320,
    parameter int          T_MAX         = 400,
    parameter int unsigned PULSE_TICKS   = 875,
    parameter int unsigned DECAY_PERIODS = 15,
    parameter int unsigned TIMER_TICKS   = 56000,
    parameter int unsigned PROBE_PERIOD  = 55,
    parameter int unsigned PROBE_OFF     = 27
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [VW-1:0]        vcell,
    input  logic signed [TW-1:0] tcell,
    input  logic                 chg_present,
    input  logic                 data_valid,
    input  logic                 start_cmd,
    input  logic                 stop_cmd,
    input  logic                 auto_start,
    input  logic                 status_wr,
    input  logic [TMW-1:0]       timer_init,
    input  logic                 timer_wr,
    input  logic [TMW-1:0]       timer_wdata,
    output logic                 fast_gate_n,
    output logic                 trickle_gate_n,
    output logic [1:0]           status
);
    localparam int unsigned PLW = $clog2(PULSE_TICKS + 1);
    localparam int unsigned PCW = $clog2(PROBE_PERIOD + 1);
    localparam int unsigned SCW = $clog2(TIMER_TICKS + 1);
    localparam logic [VW-1:0]        LB_C    = VW'(LB_CODE);
    localparam logic [VW-1:0]        CV_C    = VW'(CV_CODE);
    localparam logic signed [TW-1:0] TLO_C   = TW'(T_LO);
    localparam logic signed [TW-1:0] THI_C   = TW'(T_HI);
    localparam logic signed [TW-1:0] TMAX_C  = TW'(T_MAX);
    localparam logic [PLW-1:0]       PUL_END = PLW'(PULSE_TICKS - 1);
    localparam logic [PCW-1:0]       WIN_BEG = PCW'(PROBE_PERIOD - PROBE_OFF);
    localparam logic [SCW-1:0]       PRE_END = SCW'(TIMER_TICKS - 1);

    seq_state_t     state;
    seq_ctl_t       ctl;
    seq_in_t        cin;
    logic           chg_q, trickle_q, done_q;
    logic           fast, in_pulse, probe_win, pulse_wrap, timer_dec, timer_zero;
    logic [PLW-1:0] pulse_cnt;
    logic [PCW-1:0] probe_cnt;
    logic [SCW-1:0] pre_cnt;

    assign fast     = is_fast(state);
    assign in_pulse = (state == ST_HOLD) || (state == ST_REST);

    always_comb begin
        cin.v_lb     = (vcell >= LB_C);
        cin.v_cv     = (vcell >= CV_C);
        cin.t_ok     = (tcell >= TLO_C) && (tcell <= THI_C);
        cin.t_hot    = (tcell > TMAX_C);
        cin.chg      = chg_present;
        cin.chg_rise = chg_present && !chg_q;
        cin.dv       = data_valid;
        cin.start    = start_cmd;
        cin.stop     = stop_cmd;
        cin.auto_on  = auto_start;
    end

    pcc_interval #(.LIMIT(PULSE_TICKS), .CW(PLW)) u_pulse (
        .clk(clk), .rst(rst), .clr(ctl.pulse_clr),
        .en(tick && in_pulse), .cnt(pulse_cnt)
    );

    pcc_interval #(.LIMIT(PROBE_PERIOD), .CW(PCW)) u_probe (
        .clk(clk), .rst(rst), .clr(!fast),
        .en(tick && fast), .cnt(probe_cnt)
    );

    pcc_interval #(.LIMIT(TIMER_TICKS), .CW(SCW)) u_prescale (
        .clk(clk), .rst(rst), .clr(!fast),
        .en(tick && fast), .cnt(pre_cnt)
    );

    assign pulse_wrap = tick && in_pulse && (pulse_cnt == PUL_END);
    assign probe_win  = fast && (probe_cnt >= WIN_BEG);
    assign timer_dec  = tick && fast && (pre_cnt == PRE_END);

    pcc_charge_timer #(.TMW(TMW)) u_timer (
        .clk(clk), .rst(rst), .load(ctl.launch), .load_val(timer_init),
        .wr(timer_wr), .wdata(timer_wdata), .dec(timer_dec), .zero(timer_zero)
    );

    pcc_seq #(.DECAY_PERIODS(DECAY_PERIODS)) u_seq (
        .clk(clk), .rst(rst), .cin(cin), .probe_win(probe_win),
        .pulse_wrap(pulse_wrap), .timer_zero(timer_zero && fast),
        .state(state), .ctl(ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chg_q     <= 1'b0;
            trickle_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            chg_q     <= chg_present;
            trickle_q <= chg_present && !cin.v_lb;
            if (ctl.finish)
                done_q <= 1'b1;
            else if (status_wr)
                done_q <= 1'b0;
        end
    end

    assign fast_gate_n    = !ctl.gate_on;
    assign trickle_gate_n = !trickle_q;
    assign status         = pick_status(done_q, fast || trickle_q, chg_q);
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int unsigned VW      = 10,
    parameter int unsigned TW      = 11,
    parameter int unsigned LB_CODE = 615,
    parameter int          T_MAX   = 400
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 chg_present,
    input logic [VW-1:0]        vcell,
    input logic signed [TW-1:0] tcell,
    input logic                 stop_cmd,
    input logic                 status_wr,
    input logic                 fast_gate_n,
    input logic                 trickle_gate_n,
    input logic [1:0]           status
);
    localparam logic [VW-1:0]        LB_C   = VW'(LB_CODE);
    localparam logic signed [TW-1:0] TMAX_C = TW'(T_MAX);

    p_trickle_on_r1: assert property (@(posedge clk) disable iff (rst)
        (chg_present && (vcell < LB_C)) |=> !trickle_gate_n);

    p_trickle_off_r1: assert property (@(posedge clk) disable iff (rst)
        !(chg_present && (vcell < LB_C)) |=> trickle_gate_n);

    p_stop_aborts_r7: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> fast_gate_n);

    p_overtemp_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (!fast_gate_n && (tcell > TMAX_C) && !stop_cmd)
        |=> (fast_gate_n && (status == 2'd3)));

    p_gate_implies_charging_r10: assert property (@(posedge clk) disable iff (rst)
        !fast_gate_n |-> (status == 2'd1));

    p_done_latched_r10: assert property (@(posedge clk) disable iff (rst)
        ((status == 2'd3) && !status_wr) |=> (status == 2'd3));
endmodule

bind pulse_charge_ctrl pcc_checker #(
    .VW(VW), .TW(TW), .LB_CODE(LB_CODE), .T_MAX(T_MAX)
) u_chk (
    .clk(clk), .rst(rst), .chg_present(chg_present), .vcell(vcell),
    .tcell(tcell), .stop_cmd(stop_cmd), .status_wr(status_wr),
    .fast_gate_n(fast_gate_n), .trickle_gate_n(trickle_gate_n), .status(status)
);

// File: tb/pulse_charge_ctrl_bench.sv
`timescale 1ns/100ps
module pulse_charge_ctrl_bench;
    localparam int PT = 4;     // pulse ticks
    localparam int DP = 15;    // decay periods
    localparam int TT = 10;    // timer ticks
    localparam int PP = 200;   // probe period
    localparam int PO = 90;    // probe off ticks
    localparam int LB = 615;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic [9:0] vcell = 10'd700;
    logic signed [10:0] tcell = 11'sd200;
    logic chg_present = 1'b0, data_valid = 1'b1;
    logic start_cmd = 1'b0, stop_cmd = 1'b0, auto_start = 1'b0, status_wr = 1'b0;
    logic [7:0] timer_init = 8'd255, timer_wdata = 8'd0;
    logic timer_wr = 1'b0;
    logic fast_gate_n, trickle_gate_n;
    logic [1:0] status;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pulse_charge_ctrl #(
        .PULSE_TICKS(PT), .DECAY_PERIODS(DP), .TIMER_TICKS(TT),
        .PROBE_PERIOD(PP), .PROBE_OFF(PO)
    ) u_pulse_charge_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .vcell(vcell), .tcell(tcell),
        .chg_present(chg_present), .data_valid(data_valid),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .auto_start(auto_start),
        .status_wr(status_wr), .timer_init(timer_init), .timer_wr(timer_wr),
        .timer_wdata(timer_wdata), .fast_gate_n(fast_gate_n),
        .trickle_gate_n(trickle_gate_n), .status(status)
    );

    function automatic logic exp_trickle_n(input logic chg, input logic [9:0] v);
        return !(chg && (v < 10'(LB)));
    endfunction

    function automatic logic [1:0] exp_idle_status(input logic chg, input logic [9:0] v);
        if (chg && (v < 10'(LB))) return 2'd1;
        return chg ? 2'd2 : 2'd0;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic enter_fast();   // leaves the bench at the first fast-charge cycle
        start_cmd = 1'b1; step(); start_cmd = 1'b0; step();
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    endtask

    task automatic clear_done();
        status_wr = 1'b1; step(); status_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        steps(3); rst = 1'b0; step();
        chk("R10 reset status", status, 2'd0);
        chk("R10 reset fast gate", fast_gate_n, 1'b1);
        chk("R1 reset trickle gate", trickle_gate_n, 1'b1);

        // R1 recovery gate
        chg_present = 1'b1; vcell = 10'd500; step();
        chk("R1 trickle low", trickle_gate_n, 1'b0);
        chk("R10 trickle shows charging", status, 2'd1);
        tcell = -11'sd400; data_valid = 1'b0; step();
        chk("R1 trickle regardless of temp", trickle_gate_n, 1'b0);
        vcell = 10'd615; step();
        chk("R1 trickle released at threshold", trickle_gate_n, 1'b1);
        chk("R10 present code", status, 2'd2);
        tcell = 11'sd200; data_valid = 1'b1; vcell = 10'd700;

        // R2 attach without auto-start
        chg_present = 1'b0; step(); chg_present = 1'b1; steps(3);
        chk("R2 no auto start status", status, 2'd2);
        chk("R2 no auto start gate", fast_gate_n, 1'b1);

        // R2 auto start, R7 stop
        chg_present = 1'b0; step(); auto_start = 1'b1; chg_present = 1'b1; step();
        chk("R2 auto pending", status, 2'd2);
        step();
        chk("R2 auto start status", status, 2'd1);
        chk("R2 auto start gate", fast_gate_n, 1'b0);
        auto_start = 1'b0; do_stop();
        chk("R7 stop status", status, 2'd2);
        chk("R7 stop gate", fast_gate_n, 1'b1);

        // R3 postponement
        tcell = -11'sd8; start_cmd = 1'b1; step(); start_cmd = 1'b0; steps(4);
        chk("R3 cold postpones", status, 2'd2);
        tcell = 11'sd200; step();
        chk("R3 start after temp ok", fast_gate_n, 1'b0);
        do_stop();
        tcell = 11'sd321; start_cmd = 1'b1; step(); start_cmd = 1'b0; steps(3);
        chk("R3 hot postpones", fast_gate_n, 1'b1);
        tcell = 11'sd320; step();
        chk("R3 upper bound inclusive", status, 2'd1);
        do_stop(); tcell = 11'sd200;
        data_valid = 1'b0; start_cmd = 1'b1; step(); start_cmd = 1'b0; steps(3);
        chk("R3 invalid data postpones", status, 2'd2);
        data_valid = 1'b1; step();
        chk("R3 start after valid", fast_gate_n, 1'b0);
        do_stop();
        chg_present = 1'b0; step(); start_cmd = 1'b1; step(); start_cmd = 1'b0; steps(3);
        chk("R3 no charger postpones", status, 2'd0);
        chg_present = 1'b1; step();
        chk("R3 start on charger", fast_gate_n, 1'b0);
        do_stop();
        vcell = 10'd500; start_cmd = 1'b1; step(); start_cmd = 1'b0; steps(3);
        chk("R3 low cell postpones", fast_gate_n, 1'b1);
        chk("R1 recovery during wait", trickle_gate_n, 1'b0);
        vcell = 10'd700; step();
        chk("R3 start after recovery", fast_gate_n, 1'b0);
        chk("R1 recovery released", trickle_gate_n, 1'b1);
        do_stop();

        // R4 bulk, R6 probe windows
        enter_fast();
        chk("R4 bulk gate low k0", fast_gate_n, 1'b0);
        steps(109);
        chk("R4 bulk gate low before window", fast_gate_n, 1'b0);
        step();
        chk("R6 probe window opens", fast_gate_n, 1'b1);
        steps(89);
        chk("R6 probe window last tick", fast_gate_n, 1'b1);
        step();
        chk("R6 probe window closes", fast_gate_n, 1'b0);

        // R7 removal noticed only in a window
        chg_present = 1'b0; steps(109);
        chk("R7 removal unseen while gate low", status, 2'd1);
        steps(2);
        chk("R7 removal aborts in window", status, 2'd0);
        chg_present = 1'b1; step();

        // R4/R5 pulse region and decay termination
        vcell = 10'd900; enter_fast(); steps(4);
        chk("R4 hold gate low", fast_gate_n, 1'b0);
        step();
        chk("R4 gate high after hold", fast_gate_n, 1'b1);
        steps(59);
        chk("R5 still charging before limit", status, 2'd1);
        step();
        chk("R5 decay limit completes", status, 2'd3);
        chk("R11 gate high after done", fast_gate_n, 1'b1);
        vcell = 10'd800; step(); vcell = 10'd900; step(); vcell = 10'd800; step();
        chk("R11 crossings ignored", fast_gate_n, 1'b1);
        chk("R10 done latched", status, 2'd3);
        clear_done();
        chk("R10 write clears done", status, 2'd2);

        // R4 re-entry on decay
        vcell = 10'd900; enter_fast(); steps(5);
        chk("R4 resting", fast_gate_n, 1'b1);
        steps(2); vcell = 10'd800; step();
        chk("R4 low again on decay", fast_gate_n, 1'b0);
        vcell = 10'd900; steps(3);
        chk("R4 second hold last tick", fast_gate_n, 1'b0);
        step();
        chk("R4 second hold ends", fast_gate_n, 1'b1);
        do_stop(); vcell = 10'd700;

        // R8 over-temperature
        enter_fast(); tcell = 11'sd400; steps(3);
        chk("R8 at max keeps charging", status, 2'd1);
        tcell = 11'sd401; step();
        chk("R8 over max completes", status, 2'd3);
        chk("R8 gate released", fast_gate_n, 1'b1);
        clear_done(); tcell = 11'sd200;

        // R9 charge timer
        timer_init = 8'd3; enter_fast(); steps(30);
        chk("R9 timer not yet expired", status, 2'd1);
        step();
        chk("R9 timer expiry completes", status, 2'd3);
        clear_done();
        timer_init = 8'd200; enter_fast(); steps(5);
        timer_wr = 1'b1; timer_wdata = 8'd1; step(); timer_wr = 1'b0; steps(4);
        chk("R9 overwrite before expiry", status, 2'd1);
        step();
        chk("R9 overwritten timer expires", status, 2'd3);
        clear_done(); timer_init = 8'd255;

        // Random idle traffic: R1 and R10 against bench model
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic pc;
            logic [9:0] pv;
            chg_present = 1'($urandom_range(0, 1));
            vcell = 10'($urandom_range(400, 1000));
            tcell = 11'($signed($urandom_range(0, 900)) - 400);
            data_valid = 1'($urandom_range(0, 1));
            tick = 1'($urandom_range(0, 1));
            pc = chg_present; pv = vcell;
            step();
            chk("R1 random trickle", trickle_gate_n, exp_trickle_n(pc, pv));
            chk("R10 random status", status, exp_idle_status(pc, pv));
            chk("R2 random no start", fast_gate_n, 1'b1);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule